// File: doc/BRIEF.md
# General-purpose I/O port with per-pin interrupt detection

This block is a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. Each pin is either an output, driven from a data register, or an input, whose level software can read back after it has passed through a two-flop synchronizer. Every input pin also has its own trigger detector. A detector can fire on a low level, a high level, a rising edge or a falling edge. A separate per-pin bit makes the pin fire on both edges, whatever its trigger code says.

A detector that fires sets a sticky status bit. Software clears that bit by writing a one to it. A mask register selects which status bits may raise an interrupt. Pending interrupts are the status bits AND the mask bits. They are reduced onto two lines: one for the lower half of the pins and one for the upper half. A writer addresses a register with `bus_sel` high, `bus_wr` high and a byte offset, and the register takes the new value at the next rising clock edge. Reads are combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_irq_port`

## Requirements
- R1: While `rst_n` is low, every register reads 0, `pad_oe` is all zero and both interrupt lines are low. With all configuration at zero, every pin starts as a low-level input with its interrupt masked.
- R2: Offset 0x04 holds the direction. A bit of 1 makes the pin an output: `pad_oe` is 1 and `pad_out` carries the data bit held at offset 0x00. A bit of 0 makes `pad_oe` and `pad_out` 0 for that pin.
- R3: A read at offset 0x08 returns `pad_in` delayed by two clock edges. After a change, the first clock edge does not yet show the new value; the second clock edge does.
- R4: Trigger codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. The status bit sets at the third clock edge after the pad changes: two synchronizer edges, then the status register.
- R5: Pins 0 to 15 take their 2-bit code from offset 0x0C and pins 16 to 31 from offset 0x10. The code sits at bits 2*(pin mod 16)+1 down to 2*(pin mod 16).
- R6: A 1 in the pin's bit at offset 0x1C makes the pin fire on every change of level, in either direction. The 2-bit code is then ignored, including the level codes.
- R7: Status sits at offset 0x18 and is sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. No status bit sets without a detector firing.
- R8: When a clear and a detection of the same bit fall in one cycle, the bit stays set. A level-mode bit that is cleared while its level still holds therefore reads 1 again.
- R9: Offset 0x14 is the mask, and 1 enables the pin. `irq_lo` is the OR of status AND mask over pins 0 to 15. `irq_hi` is the same OR over pins 16 to 31.
- R10: The registers at offsets 0x00, 0x04, 0x0C, 0x10, 0x14 and 0x1C read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The hardest situation to reach from the ports is a status clear that lands in the same cycle as a fresh detection. The bench gets there by setting a pin to high-level mode, holding its pad high, and writing a one to its status bit. The detector keeps firing on every cycle, so the clear and the set coincide, and the bit must still read 1 afterwards. For each vector, the edge modes are first brought to a settled state: the bench drives the starting level, waits for the synchronizer, clears the bit and only then applies the second level. The status bit then reflects that transition alone.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_DIR  = 5'h04;
  localparam logic [4:0] OFS_PAD  = 5'h08;
  localparam logic [4:0] OFS_CFGL = 5'h0C;
  localparam logic [4:0] OFS_CFGH = 5'h10;
  localparam logic [4:0] OFS_MASK = 5'h14;
  localparam logic [4:0] OFS_STAT = 5'h18;
  localparam logic [4:0] OFS_BOTH = 5'h1C;

  // Decide whether one pin's detector fires this cycle.
  function automatic logic trig_fire(input trig_e code, input logic both,
                                     input logic cur, input logic prev);
    logic r;
    if (both) begin
      r = cur ^ prev;
    end else begin
      unique case (code)
        TRIG_LOW:  r = ~cur;
        TRIG_HIGH: r = cur;
        TRIG_RISE: r = cur & ~prev;
        default:   r = ~cur & prev;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cur,
  input  trig_e code,
  input  logic  both,
  output logic  fire
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign fire = trig_fire(code, both, cur, prev);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] reg_out, reg_dir, cfg_lo, cfg_hi, reg_en, reg_both, reg_pend;
  logic [NPINS-1:0] pad_sync, evt_hit, clr_req, pend_vec;
  logic             wr_go;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [4:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_go = bus_sel & bus_wr;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int SLOT = i % HALF;
    trig_e code;
    if (i < HALF) begin : g_lo
      assign code = trig_e'(cfg_lo[2*SLOT +: 2]);
    end else begin : g_hi
      assign code = trig_e'(cfg_hi[2*SLOT +: 2]);
    end
    gpio_trig_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cur(pad_sync[i]),
      .code(code), .both(reg_both[i]), .fire(evt_hit[i])
    );
  end

  assign clr_req = (wr_go && at(bus_addr, OFS_STAT)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_out  <= '0;
      reg_dir  <= '0;
      cfg_lo   <= '0;
      cfg_hi   <= '0;
      reg_en   <= '0;
      reg_both <= '0;
      reg_pend <= '0;
    end else begin
      if (wr_go && at(bus_addr, OFS_DATA)) reg_out  <= bus_wdata;
      if (wr_go && at(bus_addr, OFS_DIR))  reg_dir  <= bus_wdata;
      if (wr_go && at(bus_addr, OFS_CFGL)) cfg_lo   <= bus_wdata;
      if (wr_go && at(bus_addr, OFS_CFGH)) cfg_hi   <= bus_wdata;
      if (wr_go && at(bus_addr, OFS_MASK)) reg_en   <= bus_wdata;
      if (wr_go && at(bus_addr, OFS_BOTH)) reg_both <= bus_wdata;
      // Detection has priority over a simultaneous clear.
      reg_pend <= (reg_pend & ~clr_req) | evt_hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (1'b1)
        at(bus_addr, OFS_DATA): bus_rdata = reg_out;
        at(bus_addr, OFS_DIR):  bus_rdata = reg_dir;
        at(bus_addr, OFS_PAD):  bus_rdata = pad_sync;
        at(bus_addr, OFS_CFGL): bus_rdata = cfg_lo;
        at(bus_addr, OFS_CFGH): bus_rdata = cfg_hi;
        at(bus_addr, OFS_MASK): bus_rdata = reg_en;
        at(bus_addr, OFS_STAT): bus_rdata = reg_pend;
        at(bus_addr, OFS_BOTH): bus_rdata = reg_both;
        default:                bus_rdata = '0;
      endcase
    end
  end

  assign pad_oe   = reg_dir;
  assign pad_out  = reg_out & reg_dir;
  assign pend_vec = reg_pend & reg_en;
  assign irq_lo   = |pend_vec[HALF-1:0];
  assign irq_hi   = |pend_vec[NPINS-1:HALF];
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [NPINS-1:0]  reg_en,
  input logic [NPINS-1:0]  reg_pend,
  input logic [NPINS-1:0]  evt_hit,
  input logic [NPINS-1:0]  clr_req,
  input logic [NPINS-1:0]  pad_sync
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 3)  warm <= warm + 2'd1;
  end

  // R3: pad status lags the pad by two edges
  a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (pad_sync == $past(pad_in, 2)));

  // R7: a set status bit drops only when a clear was requested
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(reg_pend) & ~$past(clr_req)) & ~reg_pend) == '0));

  // R7: a status bit rises only after its detector fired
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_pend & ~$past(reg_pend) & ~$past(evt_hit)) == '0));

  // R8: detection wins over a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_req) & $past(evt_hit)) & ~reg_pend) == '0));

  // R9: nothing enabled means both lines quiet
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en == '0) |-> (!irq_lo && !irq_hi));

  // R2: a direction write shows up on the output enables
  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == $past(bus_wdata)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi), .reg_en(reg_en),
  .reg_pend(reg_pend), .evt_hit(evt_hit), .clr_req(clr_req),
  .pad_sync(pad_sync)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int n_chk = 0, n_bad = 0;
  logic [31:0] sh_lo = '0, sh_hi = '0, sh_both = '0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {pin[4:0], code[1:0], both, v0, v1, expected}
  localparam logic [10:0] VEC [12] = '{
    {5'd0,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd15, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd16, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd5,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd20, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd9,  2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd27, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd3,  2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd30, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd12, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'd17, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_trig(input int pin, input logic [1:0] code, input logic both);
    int sl = (pin % 16) * 2;
    if (pin < 16) begin sh_lo[sl +: 2] = code; end
    else          begin sh_hi[sl +: 2] = code; end
    sh_both[pin] = both;
    wr(5'h0C, sh_lo);
    wr(5'h10, sh_hi);
    wr(5'h1C, sh_both);
  endtask

  task automatic drive_pin(input int pin, input logic v);
    @(negedge clk);
    pad_in[pin] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    rd(5'h18, d); check(d == 0, "R1 status", d, 0);
    rd(5'h04, d); check(d == 0, "R1 direction", d, 0);
    rd(5'h14, d); check(d == 0, "R1 mask", d, 0);
    check(pad_oe == 0 && !irq_lo && !irq_hi, "R1 outputs", {pad_oe[29:0], irq_hi, irq_lo}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R10: readback
    wr(5'h00, 32'h1234_5678); rd(5'h00, d); check(d == 32'h1234_5678, "R10 data", d, 32'h1234_5678);
    wr(5'h0C, 32'hA5A5_0F0F); rd(5'h0C, d); check(d == 32'hA5A5_0F0F, "R10 cfg low", d, 32'hA5A5_0F0F);
    wr(5'h1C, 32'h8000_0001); rd(5'h1C, d); check(d == 32'h8000_0001, "R10 both", d, 32'h8000_0001);
    wr(5'h14, 32'h00F0_0F00); rd(5'h14, d); check(d == 32'h00F0_0F00, "R10 mask", d, 32'h00F0_0F00);
    wr(5'h0C, 0); wr(5'h1C, 0); wr(5'h14, 0);

    // R2: direction and output data
    wr(5'h04, 32'hFFFF_0000);
    #1 check(pad_oe == 32'hFFFF_0000, "R2 oe", pad_oe, 32'hFFFF_0000);
    check(pad_out == 32'h1234_0000, "R2 out", pad_out, 32'h1234_0000);
    wr(5'h04, 0);
    #1 check(pad_oe == 0 && pad_out == 0, "R2 released", pad_oe | pad_out, 0);

    // R3: pad status latency
    @(negedge clk); pad_in = 32'hCAFE_1234;
    @(negedge clk); #1 bus_sel = 1; bus_wr = 0; bus_addr = 5'h08;
    #1 check(bus_rdata == 0, "R3 one edge", bus_rdata, 0);
    @(negedge clk); #1 check(bus_rdata == 32'hCAFE_1234, "R3 two edges", bus_rdata, 32'hCAFE_1234);
    bus_sel = 0;
    @(negedge clk); pad_in = '0;
    repeat (3) @(negedge clk);

    // R4 R5 R6: vector table
    for (int k = 0; k < 12; k++) begin
      int pin = int'(VEC[k][10:6]);
      set_trig(pin, VEC[k][5:4], VEC[k][3]);
      drive_pin(pin, VEC[k][2]);
      wr(5'h18, 32'h1 << pin);
      drive_pin(pin, VEC[k][1]);
      rd(5'h18, d);
      check(d[pin] == VEC[k][0], $sformatf("R4/R5/R6 vector %0d pin %0d", k, pin),
            {31'd0, d[pin]}, {31'd0, VEC[k][0]});
    end

    // R4: status sets on the third edge after a rising pad
    set_trig(7, 2'd2, 1'b0);
    drive_pin(7, 1'b0); wr(5'h18, 32'h80);
    @(negedge clk); pad_in[7] = 1'b1;
    @(negedge clk); @(negedge clk); #1 bus_sel = 1; bus_wr = 0; bus_addr = 5'h18;
    #1 check(bus_rdata[7] == 1'b0, "R4 edge two", {31'd0, bus_rdata[7]}, 0);
    @(negedge clk); #1 check(bus_rdata[7] == 1'b1, "R4 edge three", {31'd0, bus_rdata[7]}, 1);
    bus_sel = 0;

    // R7: write 0 keeps, write 1 clears
    wr(5'h18, 32'h0); rd(5'h18, d); check(d[7] == 1'b1, "R7 zero write", {31'd0, d[7]}, 1);
    wr(5'h18, 32'h80); rd(5'h18, d); check(d[7] == 1'b0, "R7 one write", {31'd0, d[7]}, 0);

    // R8: clear while high level held
    set_trig(4, 2'd1, 1'b0);
    drive_pin(4, 1'b1);
    wr(5'h18, 32'h10); rd(5'h18, d); check(d[4] == 1'b1, "R8 set wins", {31'd0, d[4]}, 1);

    // R9: masking and split lines
    set_trig(2, 2'd2, 1'b0); set_trig(18, 2'd2, 1'b0);
    drive_pin(2, 1'b0); drive_pin(18, 1'b0);
    wr(5'h18, 32'h0004_0004);
    drive_pin(2, 1'b1);
    #1 check(!irq_lo && !irq_hi, "R9 masked", {30'd0, irq_hi, irq_lo}, 0);
    wr(5'h14, 32'h0000_0004);
    #1 check(irq_lo && !irq_hi, "R9 low line", {30'd0, irq_hi, irq_lo}, 1);
    wr(5'h14, 32'h0004_0000);
    #1 check(!irq_lo && !irq_hi, "R9 high masked", {30'd0, irq_hi, irq_lo}, 0);
    drive_pin(18, 1'b1);
    #1 check(!irq_lo && irq_hi, "R9 high line", {30'd0, irq_hi, irq_lo}, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule